// File: doc/BRIEF.md
# UART receive FIFO with interrupt identification

This block sits between a serial receiver and the register interface of a UART. Each completed character arrives with a strobe, its data bits and three error flags (parity, framing, break). The block stores character and flags together in a first-in first-out queue of 16 entries. It presents the oldest character and a set of line status bits. When the queue is full, an arriving character is dropped and an overrun is recorded.

An interrupt request is formed from four sources: line status errors, data available at a selectable fill threshold, a character time-out, and an empty transmit holding register reported by the transmitter. Each source has an enable. The highest-priority enabled source is reported as a 3-bit code, together with an active-low pending flag. With the queue switched off, the block acts as a one-character holding register.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: After reset, data ready, overrun, parity, framing, break and error-in-queue are 0, the pending output is 1 and the code is 000.
- R2: With the queue enabled, up to 16 characters are held and read out in arrival order. Data ready is 1 whenever at least one is held, and a data read strobe removes the oldest.
- R3: A character that completes while the queue is at capacity, with no read in the same cycle, is discarded and sets the overrun bit.
- R4: Trigger select 00/01/10/11 makes data-available active when at least 1/4/8/14 characters are held.
- R5: A receive-clear pulse empties the queue, so data ready is 0 from the next cycle on. A change of the queue enable also empties the queue.
- R6: The parity (flag 0), framing (flag 1) and break (flag 2) flags of an entry are ORed into the sticky status bits when that entry becomes the oldest. The sticky bits and overrun stay set until a status read strobe clears them.
- R7: Error-in-queue is 1 while at least one held entry carries any error flag, and it is always 0 while the queue is disabled.
- R8: Character time-out is active when the queue is enabled and non-empty, is below its trigger level, and has seen no character strobe or data read for 4*CHAR_CYCLES clock cycles.
- R9: The codes are 011 for line status (any of overrun, parity, framing, break set), 010 for data available, 110 for time-out and 001 for transmit holding empty. They are reported in that priority order, highest first, and 000 is reported when nothing is pending.
- R10: Line status is gated by its enable, both data-available and time-out by the data enable, and transmit-empty by its enable. A disabled source is never reported.
- R11: With the queue disabled, capacity is one character and the trigger level is one character.
- R12: The pending output is 0 exactly when a code other than 000 is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Character complete strobe from receiver |
| rx_data_i | input | DATA_W | Received character |
| rx_perr_i | input | 1 | Parity error of the character |
| rx_ferr_i | input | 1 | Framing error of the character |
| rx_brk_i | input | 1 | Break condition of the character |
| thr_empty_i | input | 1 | Transmit holding register empty |
| fifo_en_i | input | 1 | Queue enable (0: single holding register) |
| rx_clr_i | input | 1 | Receive queue clear pulse |
| trig_sel_i | input | 2 | Data-available threshold select |
| ie_rda_i | input | 1 | Enable for data available and time-out |
| ie_thre_i | input | 1 | Enable for transmit holding empty |
| ie_rls_i | input | 1 | Enable for line status |
| rd_data_i | input | 1 | Data read strobe, pops oldest character |
| rd_stat_i | input | 1 | Status read strobe, clears sticky bits |
| rdata_o | output | DATA_W | Oldest held character |
| dr_o | output | 1 | Data ready |
| oe_o | output | 1 | Overrun (sticky) |
| pe_o | output | 1 | Parity error (sticky) |
| fe_o | output | 1 | Framing error (sticky) |
| bi_o | output | 1 | Break (sticky) |
| rxfe_o | output | 1 | Error present among held entries |
| int_n_o | output | 1 | Interrupt pending, active low |
| int_id_o | output | 3 | Interrupt identification code |

## Verification
Directed runs fill the queue in order, overfill it, and walk each trigger threshold one character either side. These runs separate a wrong capacity, a lost ordering and an off-by-one threshold. Entries carrying errors are placed behind clean ones, which shows whether the flags reach the status bits only at the head, and whether a status read clears them. A single held character left idle checks the time-out against the cycle count, while priority and enable runs hold several sources pending at once. A long random mix of pushes, pops, status reads, clears, enable toggles and changing enables and thresholds is compared every cycle against a queue model kept in the bench.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  typedef enum logic [2:0] {
    IID_NONE = 3'b000,
    IID_THRE = 3'b001,
    IID_RDA  = 3'b010,
    IID_RLS  = 3'b011,
    IID_CTI  = 3'b110
  } iid_e;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter  int DEPTH = 16,
  parameter  int W     = 11,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  head_o,
  output logic [W-1:0]  next_o,
  output logic [CW-1:0] count_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  assign head_o = mem[rd_ptr];
  assign next_o = mem[nxt(rd_ptr)];

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  p_push_room_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_o < CW'(DEPTH)) || pop_i);
  p_pop_nonempty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_o != '0);
endmodule

// File: rtl/uart_rxq_tmo.sv
module uart_rxq_tmo #(
  parameter  int LIMIT = 640,
  localparam int TW    = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic armed_i,
  output logic hit_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i || !armed_i)  cnt_q <= '0;
    else if (cnt_q != TW'(LIMIT))    cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == TW'(LIMIT));

  p_tmo_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !hit_o);
endmodule

// File: rtl/uart_rxq_irq.sv
module uart_rxq_irq
  import uart_rxq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ls_i,
  input  logic       rda_i,
  input  logic       cti_i,
  input  logic       thre_i,
  input  logic       ie_rls_i,
  input  logic       ie_rda_i,
  input  logic       ie_thre_i,
  output logic [2:0] int_id_o,
  output logic       int_n_o
);
  iid_e id;

  always_comb begin
    if (ie_rls_i && ls_i)        id = IID_RLS;
    else if (ie_rda_i && rda_i)  id = IID_RDA;
    else if (ie_rda_i && cti_i)  id = IID_CTI;
    else if (ie_thre_i && thre_i) id = IID_THRE;
    else                         id = IID_NONE;
  end

  assign int_id_o = id;
  assign int_n_o  = (id == IID_NONE);

  p_rls_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_rls_i && ls_i) |-> int_id_o == 3'b011);
  p_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_rls_i && !ie_rda_i && !ie_thre_i) |-> int_n_o);
  p_pending_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_thre_i && thre_i) |-> !int_n_o);
endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int DATA_W      = 8,
  parameter int CHAR_CYCLES = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              rx_brk_i,
  input  logic              thr_empty_i,
  input  logic              fifo_en_i,
  input  logic              rx_clr_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              ie_rda_i,
  input  logic              ie_thre_i,
  input  logic              ie_rls_i,
  input  logic              rd_data_i,
  input  logic              rd_stat_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dr_o,
  output logic              oe_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              bi_o,
  output logic              rxfe_o,
  output logic              int_n_o,
  output logic [2:0]        int_id_o
);
  localparam int EW    = DATA_W + 3;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int LIMIT = 4 * CHAR_CYCLES;

  logic [EW-1:0] head, nxt_e, wentry;
  logic [CW-1:0] count, cap, lvl, err_cnt;
  logic en_q, flush, full, push, pop, rda, tmo_hit, cti, ls;
  logic head_from_in, head_from_nxt;
  logic [2:0] set_flags;
  logic oe_q, pe_q, fe_q, bi_q;

  // queue is emptied on a clear pulse or on any change of the enable
  assign flush  = rx_clr_i || (fifo_en_i != en_q);
  assign cap    = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign full   = (count >= cap);
  assign pop    = rd_data_i && !flush && (count != '0);
  assign push   = rx_valid_i && !flush && (!full || pop);
  assign wentry = {rx_brk_i, rx_ferr_i, rx_perr_i, rx_data_i};

  uart_rxq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(push), .pop_i(pop),
    .wdata_i(wentry), .head_o(head), .next_o(nxt_e), .count_o(count)
  );

  // entry that becomes the head at this edge
  assign head_from_in  = push && ((count == '0) || (count == CW'(1) && pop));
  assign head_from_nxt = pop && (count >= CW'(2));
  always_comb begin
    set_flags = '0;
    if (head_from_in)  set_flags = wentry[EW-1:DATA_W];
    if (head_from_nxt) set_flags = nxt_e[EW-1:DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      err_cnt <= '0;
      oe_q    <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      bi_q    <= 1'b0;
    end else begin
      en_q <= fifo_en_i;
      if (flush) err_cnt <= '0;
      else err_cnt <= err_cnt + CW'(push && (|wentry[EW-1:DATA_W]))
                              - CW'(pop && (|head[EW-1:DATA_W]));
      oe_q <= (oe_q && !rd_stat_i) || (rx_valid_i && !flush && full && !pop);
      pe_q <= (pe_q && !rd_stat_i) || set_flags[0];
      fe_q <= (fe_q && !rd_stat_i) || set_flags[1];
      bi_q <= (bi_q && !rd_stat_i) || set_flags[2];
    end
  end

  assign lvl = fifo_en_i ? CW'(trig_level(trig_sel_i)) : CW'(1);
  assign rda = (count >= lvl);

  uart_rxq_tmo #(.LIMIT(LIMIT)) u_tmo (
    .clk_i, .rst_ni,
    .restart_i(rx_valid_i || rd_data_i || flush),
    .armed_i(fifo_en_i && (count != '0)),
    .hit_o(tmo_hit)
  );
  assign cti = tmo_hit && fifo_en_i && (count != '0) && !rda;

  assign ls = oe_q || pe_q || fe_q || bi_q;

  uart_rxq_irq u_irq (
    .clk_i, .rst_ni, .ls_i(ls), .rda_i(rda), .cti_i(cti), .thre_i(thr_empty_i),
    .ie_rls_i, .ie_rda_i, .ie_thre_i, .int_id_o, .int_n_o
  );

  assign rdata_o = head[DATA_W-1:0];
  assign dr_o    = (count != '0);
  assign oe_o    = oe_q;
  assign pe_o    = pe_q;
  assign fe_o    = fe_q;
  assign bi_o    = bi_q;
  assign rxfe_o  = fifo_en_i && (err_cnt != '0);

  p_dr_after_push_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !flush) |=> dr_o);
  p_overrun_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !flush && full && !rd_data_i) |=> oe_o);
  p_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr_i |=> !dr_o);
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !rd_stat_i) |=> oe_o);
  p_rxfe_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> !rxfe_o);
  p_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && en_q == fifo_en_i) |-> count <= CW'(1));
endmodule

// File: tb/uart_rx_fifo_irq_test.sv
module uart_rx_fifo_irq_test;
  localparam int CLK_PERIOD  = 10;
  localparam int DEPTH       = 16;
  localparam int CHAR_CYCLES = 8;
  localparam int LIMIT       = 4 * CHAR_CYCLES;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_valid_i = 0, rx_perr_i = 0, rx_ferr_i = 0, rx_brk_i = 0;
  logic [7:0] rx_data_i = '0;
  logic thr_empty_i = 0, fifo_en_i = 1, rx_clr_i = 0;
  logic [1:0] trig_sel_i = 0;
  logic ie_rda_i = 0, ie_thre_i = 0, ie_rls_i = 0, rd_data_i = 0, rd_stat_i = 0;
  logic [7:0] rdata_o;
  logic dr_o, oe_o, pe_o, fe_o, bi_o, rxfe_o, int_n_o;
  logic [2:0] int_id_o;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  uart_rx_fifo_irq #(.DEPTH(DEPTH), .DATA_W(8), .CHAR_CYCLES(CHAR_CYCLES)) uut (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i, .rx_perr_i, .rx_ferr_i, .rx_brk_i,
    .thr_empty_i, .fifo_en_i, .rx_clr_i, .trig_sel_i, .ie_rda_i, .ie_thre_i,
    .ie_rls_i, .rd_data_i, .rd_stat_i, .rdata_o, .dr_o, .oe_o, .pe_o, .fe_o,
    .bi_o, .rxfe_o, .int_n_o, .int_id_o
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model: entry = {brk, fe, pe, data}
  logic [10:0] q[$];
  bit m_oe, m_pe, m_fe, m_bi, m_enq;
  int idle;

  function automatic int lvl_of(input bit en, input logic [1:0] s);
    if (!en) return 1;
    case (s) 2'b00: return 1; 2'b01: return 4; 2'b10: return 8; default: return 14; endcase
  endfunction

  function automatic logic [2:0] exp_id();
    int n = q.size();
    bit rda = n >= lvl_of(fifo_en_i, trig_sel_i);
    bit cti = fifo_en_i && idle == LIMIT && n > 0 && !rda;
    if (ie_rls_i && (m_oe | m_pe | m_fe | m_bi)) return 3'b011;
    if (ie_rda_i && rda) return 3'b010;
    if (ie_rda_i && cti) return 3'b110;
    if (ie_thre_i && thr_empty_i) return 3'b001;
    return 3'b000;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    bit any_err = 0;
    foreach (q[i]) if (|q[i][10:8]) any_err = 1;
    chk(tag, "dr", {7'd0, dr_o}, {7'd0, q.size() > 0});
    if (q.size() > 0) chk(tag, "rdata", rdata_o, q[0][7:0]);
    chk(tag, "oe", {7'd0, oe_o}, {7'd0, m_oe});
    chk(tag, "pe", {7'd0, pe_o}, {7'd0, m_pe});
    chk(tag, "fe", {7'd0, fe_o}, {7'd0, m_fe});
    chk(tag, "bi", {7'd0, bi_o}, {7'd0, m_bi});
    chk(tag, "rxfe", {7'd0, rxfe_o}, {7'd0, fifo_en_i && any_err});
    chk(tag, "id", {5'd0, int_id_o}, {5'd0, exp_id()});
    chk(tag, "int_n", {7'd0, int_n_o}, {7'd0, exp_id() == 3'b000});
  endtask

  task automatic merge(input logic [10:0] e);
    m_pe |= e[8]; m_fe |= e[9]; m_bi |= e[10];
  endtask

  task automatic do_cycle(input bit v, input logic [7:0] d, input bit p, input bit f,
                          input bit b, input bit rdd, input bit rds, input bit clr,
                          input string tag);
    int pre = q.size();
    int cap = fifo_en_i ? DEPTH : 1;
    bit fl = clr || (fifo_en_i != m_enq);
    bit popped, acc;
    logic [10:0] e = {b, f, p, d};
    rx_valid_i = v; rx_data_i = d; rx_perr_i = p; rx_ferr_i = f; rx_brk_i = b;
    rd_data_i = rdd; rd_stat_i = rds; rx_clr_i = clr;
    if (rds) begin m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; end
    if (fl) q.delete();
    else begin
      popped = rdd && pre > 0;
      acc = v && (pre < cap || popped);
      if (v && !acc) m_oe = 1;
      if (popped) begin
        void'(q.pop_front());
        if (q.size() > 0) merge(q[0]);
      end
      if (acc) begin
        if (q.size() == 0) merge(e);
        q.push_back(e);
      end
    end
    if (v || rdd || fl || pre == 0 || !fifo_en_i) idle = 0;
    else if (idle < LIMIT) idle++;
    m_enq = fifo_en_i;
    @(posedge clk_i);
    @(negedge clk_i);
    rx_valid_i = 0; rd_data_i = 0; rd_stat_i = 0; rx_clr_i = 0;
    check_all(tag);
  endtask

  task automatic push(input logic [7:0] d, input bit p, input bit f, input bit b, input string tag);
    do_cycle(1, d, p, f, b, 0, 0, 0, tag);
  endtask
  task automatic pop(input string tag);  do_cycle(0, 0, 0, 0, 0, 1, 0, 0, tag); endtask
  task automatic rstat(input string tag); do_cycle(0, 0, 0, 0, 0, 0, 1, 0, tag); endtask
  task automatic clr(input string tag);  do_cycle(0, 0, 0, 0, 0, 0, 0, 1, tag); endtask
  task automatic nop(input string tag);  do_cycle(0, 0, 0, 0, 0, 0, 0, 0, tag); endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_enq = 0; idle = 0;
    repeat (3) @(negedge clk_i);
    check_all("R1");
    rst_ni = 1;
    check_all("R1");
    nop("R1");
    nop("R1");

    // R2 ordering, full depth
    for (int i = 0; i < DEPTH; i++) push(8'h10 + 8'(i), 0, 0, 0, "R2");
    for (int i = 0; i < DEPTH; i++) pop("R2");

    // R3 overrun drops 17th
    for (int i = 0; i < DEPTH; i++) push(8'h40 + 8'(i), 0, 0, 0, "R3");
    push(8'hEE, 0, 0, 0, "R3");
    for (int i = 0; i < DEPTH; i++) pop("R3");
    rstat("R6");

    // R4 trigger thresholds
    ie_rda_i = 1;
    for (int s = 0; s < 4; s++) begin
      trig_sel_i = 2'(s);
      clr("R4");
      for (int i = 0; i < lvl_of(1, 2'(s)); i++) push(8'(s * 16 + i), 0, 0, 0, "R4");
    end

    // R5 clear
    clr("R5");
    for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i), 0, 0, 0, "R5");
    clr("R5");
    nop("R5");

    // R6/R7 flags merged at head, sticky, cleared by status read
    ie_rls_i = 1;
    push(8'h01, 0, 0, 0, "R6");
    push(8'h02, 1, 0, 0, "R7");
    push(8'h03, 0, 1, 1, "R7");
    pop("R6");
    rstat("R6");
    pop("R6");
    rstat("R6");
    pop("R7");

    // R8 time-out
    trig_sel_i = 2'b01;
    push(8'h55, 0, 0, 0, "R8");
    for (int i = 0; i < LIMIT + 3; i++) nop("R8");
    push(8'h56, 0, 0, 0, "R8");
    pop("R8");
    pop("R8");

    // R9/R12 priority
    ie_rls_i = 1; ie_rda_i = 1; ie_thre_i = 1; thr_empty_i = 1; trig_sel_i = 2'b00;
    push(8'h77, 1, 0, 0, "R9");
    rstat("R9");
    pop("R12");
    thr_empty_i = 0;
    nop("R12");

    // R10 enables gate sources
    thr_empty_i = 1;
    push(8'h78, 0, 1, 0, "R10");
    ie_rls_i = 0; ie_rda_i = 0; ie_thre_i = 0;
    nop("R10");
    ie_thre_i = 1;
    nop("R10");
    rstat("R10");
    pop("R10");

    // R11 disabled queue: one entry, rxfe off
    fifo_en_i = 0;
    nop("R11");
    push(8'h90, 1, 0, 0, "R11");
    push(8'h91, 0, 0, 0, "R11");
    pop("R11");
    rstat("R11");
    fifo_en_i = 1;
    nop("R11");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 15);
      ie_rda_i = 1'($urandom); ie_rls_i = 1'($urandom); ie_thre_i = 1'($urandom);
      thr_empty_i = 1'($urandom);
      if ($urandom_range(0, 30) == 0) trig_sel_i = 2'($urandom);
      if ($urandom_range(0, 150) == 0) fifo_en_i = ~fifo_en_i;
      if (op < 6)
        push(8'($urandom), $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
             $urandom_range(0, 15) == 0, "R2");
      else if (op < 10) pop("R3");
      else if (op == 10) rstat("R6");
      else if (op == 11 && $urandom_range(0, 5) == 0) clr("R5");
      else nop("R9");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule